// File: doc/BRIEF.md
# Shadowed Settings Commit Controller

This block is the register front end of a frame-based video generator. A host reaches it through a simple memory-mapped port with a write strobe and a read strobe. The block holds eight 32-bit settings: four pattern settings and four auxiliary settings. It passes those settings to the frame logic only at field boundaries. The frame logic reports each boundary with a one-cycle pulse on `field_bnd`.

In full mode (`LITE = 0`), host writes land in shadow copies. A write of any value to the commit register causes every shadow value to become active together at the next field boundary. A status bit shows that edits are waiting to be applied. In lite mode (`LITE = 1`), the commit register does not exist. Shadow values are then loaded at the boundary where the generator moves from stopped to running.

The run/stop control register is never gated by commit. Alongside the settings, the block keeps a saturating field index and an interlace phase. An applied update that touches a pattern setting resets the index to zero and reloads the phase from a start-field bit.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: In full mode, setting writes leave `act_pat`/`act_aux` unchanged until the first `field_bnd` pulse after a write to the commit register (offset 0x14C). At that boundary every shadow value becomes active together, and the change is visible on the clock edge that samples the pulse.
- R2: If a commit write and a `field_bnd` pulse occur in the same cycle, the transfer is deferred to the next `field_bnd` pulse.
- R3: Status (offset 0x140) bit 1 reads 1 from the first setting write after the last applied update. It reads 0 again after the boundary that applies the committed set. In lite mode it always reads 0.
- R4: Control (offset 0x148) bit 0 is the run request: 1 runs and 0 stops. A new value reaches `gen_run` and status bit 0 only at the next `field_bnd`, needs no commit, and does not set status bit 1.
- R5: At each boundary where the generator runs the following field and no pattern update is applied, `field_idx` increments by one, saturating at 2^FIDX_W-1. `field_idx` holds at boundaries where the generator is stopped.
- R6: `field_phase` toggles at each running boundary. An applied update that includes a pattern setting (offsets 0x120, 0x124, 0x128, 0x150) sets `field_idx` to 0 and loads `field_phase` from bit 0 of offset 0x150. An update of auxiliary settings only (offsets 0x15C, 0x160, 0x164, 0x168) resets neither.
- R7: In lite mode, offset 0x14C is unmapped. Shadow values become active only at the `field_bnd` where the generator goes from stopped to running with control bit 0 set. Setting writes made while running stay in shadow.
- R8: Reads of setting offsets return the shadow value, one cycle after `h_rd`. Reads of the commit offset and of unmapped offsets return 0. Writes to unmapped offsets change no setting.
- R9: After reset, all settings and outputs are 0, the generator is stopped and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Read data, valid the cycle after `h_rd` |
| field_bnd | input | 1 | One-cycle field boundary pulse from the frame logic |
| act_pat | output | 4*DATA_W | Active pattern settings, slot 0 in the low bits |
| act_aux | output | 4*DATA_W | Active auxiliary settings, slot 0 in the low bits |
| gen_run | output | 1 | Generator is producing fields |
| field_idx | output | FIDX_W | Fields since the last pattern update, saturating |
| field_phase | output | 1 | Current interlace phase (0 = F0, 1 = F1) |

## Verification
The assertions assume that `field_bnd` is the only event at which the active settings, the run state, the field index or the phase may move. They also assume that reset holds `field_bnd` low. The bench drives every strobe and boundary pulse for exactly one cycle, starting on a falling edge, and pulses `field_bnd` only with reset released. It keeps host writes and boundary pulses in separate cycles, except in the one deliberate commit-on-boundary case.

// File: rtl/shadow_commit_pkg.sv
package shadow_commit_pkg;

    localparam int NUM_PAT = 4;
    localparam int NUM_AUX = 4;
    localparam int NUM_SET = NUM_PAT + NUM_AUX;
    localparam int OFS_W   = 9;

    typedef logic [OFS_W-1:0] ofs_t;

    localparam ofs_t OFS_STATUS  = 9'h140;
    localparam ofs_t OFS_CONTROL = 9'h148;
    localparam ofs_t OFS_COMMIT  = 9'h14C;

    // register holding the start-field selection, and its bit
    localparam int START_REG = 3;
    localparam int START_BIT = 0;

    // status bit positions
    localparam int ST_RUN  = 0;
    localparam int ST_PEND = 1;

    // byte offset of setting slot idx (pattern slots first, then auxiliary)
    function automatic ofs_t set_offset(input int idx);
        case (idx)
            0:       return 9'h120;
            1:       return 9'h124;
            2:       return 9'h128;
            3:       return 9'h150;
            4:       return 9'h15C;
            5:       return 9'h160;
            6:       return 9'h164;
            default: return 9'h168;
        endcase
    endfunction

    function automatic logic is_pattern(input int idx);
        return idx < NUM_PAT;
    endfunction

    typedef struct packed {
        logic [NUM_SET-1:0] set_hit;
        logic               any_set;
        logic               any_pat;
        logic               status;
        logic               control;
        logic               commit;
    } dec_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import shadow_commit_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter bit LITE   = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec = '0;
        for (int i = 0; i < NUM_SET; i++) begin
            if (addr == ADDR_W'(set_offset(i))) begin
                dec.set_hit[i] = 1'b1;
                dec.any_set    = 1'b1;
                if (is_pattern(i)) dec.any_pat = 1'b1;
            end
        end
        dec.status  = (addr == ADDR_W'(OFS_STATUS));
        dec.control = (addr == ADDR_W'(OFS_CONTROL));
        dec.commit  = !LITE && (addr == ADDR_W'(OFS_COMMIT));
    end

endmodule

// File: rtl/sc_bank.sv
module sc_bank
    import shadow_commit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [NUM_SET-1:0]        hit,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      load,
    output logic [NUM_SET*DATA_W-1:0] shadow,
    output logic [NUM_SET*DATA_W-1:0] active
);

    for (genvar g = 0; g < NUM_SET; g++) begin : g_slot
        logic [DATA_W-1:0] sh_q;
        logic [DATA_W-1:0] ac_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
            end else if (wr && hit[g]) begin
                sh_q <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ac_q <= '0;
            end else if (load) begin
                ac_q <= sh_q;
            end
        end

        assign shadow[g*DATA_W +: DATA_W] = sh_q;
        assign active[g*DATA_W +: DATA_W] = ac_q;
    end

endmodule

// File: rtl/sc_seq.sv
module sc_seq #(
    parameter int FIDX_W = 8,
    parameter bit LITE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_bnd,
    input  logic              set_wr,
    input  logic              pat_wr,
    input  logic              ctl_wr,
    input  logic              ctl_val,
    input  logic              commit_wr,
    input  logic              start_sel,
    output logic              load,
    output logic              run_q,
    output logic              ctl_req,
    output logic              pending,
    output logic [FIDX_W-1:0] fidx,
    output logic              phase
);

    localparam logic [FIDX_W-1:0] FIDX_MAX = '1;

    logic armed;
    logic pat_dirty;
    logic restart;

    assign restart = !run_q && ctl_req;
    assign load    = field_bnd && (LITE ? restart : armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            pat_dirty <= 1'b0;
            pending   <= 1'b0;
            ctl_req   <= 1'b0;
            run_q     <= 1'b0;
            fidx      <= '0;
            phase     <= 1'b0;
        end else begin
            if (commit_wr)      armed <= 1'b1;
            else if (load)      armed <= 1'b0;

            if (pat_wr)         pat_dirty <= 1'b1;
            else if (load)      pat_dirty <= 1'b0;

            if (!LITE && set_wr) pending <= 1'b1;
            else if (load)       pending <= 1'b0;

            if (ctl_wr)         ctl_req <= ctl_val;

            if (field_bnd) begin
                run_q <= ctl_req;
                if (load && pat_dirty) begin
                    fidx  <= '0;
                    phase <= start_sel;
                end else if (ctl_req) begin
                    if (fidx != FIDX_MAX) fidx <= fidx + 1'b1;
                    phase <= ~phase;
                end
            end
        end
    end

endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
    import shadow_commit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int FIDX_W = 8,
    parameter bit LITE   = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      h_wr,
    input  logic                      h_rd,
    input  logic [ADDR_W-1:0]         h_addr,
    input  logic [DATA_W-1:0]         h_wdata,
    output logic [DATA_W-1:0]         h_rdata,
    input  logic                      field_bnd,
    output logic [NUM_PAT*DATA_W-1:0] act_pat,
    output logic [NUM_AUX*DATA_W-1:0] act_aux,
    output logic                      gen_run,
    output logic [FIDX_W-1:0]         field_idx,
    output logic                      field_phase
);

    localparam int BANK_W = NUM_SET * DATA_W;
    localparam int PAT_W  = NUM_PAT * DATA_W;

    dec_t              dec;
    logic [BANK_W-1:0] shadow;
    logic [BANK_W-1:0] active;
    logic              load;
    logic              ctl_req;
    logic              pending;
    logic              start_sel;
    logic [DATA_W-1:0] rd_mux;

    sc_decode #(.ADDR_W(ADDR_W), .LITE(LITE)) u_dec (
        .addr (h_addr),
        .dec  (dec)
    );

    sc_bank #(.DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr     (h_wr),
        .hit    (dec.set_hit),
        .wdata  (h_wdata),
        .load   (load),
        .shadow (shadow),
        .active (active)
    );

    assign start_sel = shadow[START_REG*DATA_W + START_BIT];

    sc_seq #(.FIDX_W(FIDX_W), .LITE(LITE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .field_bnd (field_bnd),
        .set_wr    (h_wr && dec.any_set),
        .pat_wr    (h_wr && dec.any_pat),
        .ctl_wr    (h_wr && dec.control),
        .ctl_val   (h_wdata[0]),
        .commit_wr (h_wr && dec.commit),
        .start_sel (start_sel),
        .load      (load),
        .run_q     (gen_run),
        .ctl_req   (ctl_req),
        .pending   (pending),
        .fidx      (field_idx),
        .phase     (field_phase)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SET; i++) begin
            if (dec.set_hit[i]) rd_mux = shadow[i*DATA_W +: DATA_W];
        end
        if (dec.status) begin
            rd_mux[ST_RUN]  = gen_run;
            rd_mux[ST_PEND] = pending;
        end
        if (dec.control) rd_mux[0] = ctl_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else if (h_rd) begin
            h_rdata <= rd_mux;
        end
    end

    assign act_pat = active[PAT_W-1:0];
    assign act_aux = active[BANK_W-1:PAT_W];

endmodule

// File: rtl/shadow_commit_chk.sv
module shadow_commit_chk #(
    parameter int AW     = 256,
    parameter int FIDX_W = 8,
    parameter bit LITE   = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              field_bnd,
    input logic              load,
    input logic              ctl_req,
    input logic              pending,
    input logic [AW-1:0]     act_all,
    input logic              gen_run,
    input logic [FIDX_W-1:0] field_idx,
    input logic              field_phase
);

    localparam logic [FIDX_W-1:0] FMAX = '1;

    // R1: active settings move only on a boundary
    a_r1_active_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(field_bnd) |-> $stable(act_all));

    // R4: run state follows the request only at a boundary
    a_r4_run_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$past(field_bnd) |-> $stable(gen_run));

    a_r4_run_follows_req: assert property (@(posedge clk) disable iff (rst)
        $past(field_bnd) |-> gen_run == $past(ctl_req));

    // R3: pending clears only where a committed set is applied
    a_r3_pending_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(load));

    // R3: lite mode never reports pending edits
    a_r3_lite_no_pending: assert property (@(posedge clk) disable iff (rst)
        LITE |-> !pending);

    // R5: field index and phase stay put between boundaries
    a_r5_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(field_bnd) |-> ($stable(field_idx) && $stable(field_phase)));

    // R5: plain running boundary increments below saturation
    a_r5_idx_step: assert property (@(posedge clk) disable iff (rst)
        ($past(field_bnd) && !$past(load) && $past(ctl_req) && $past(field_idx) != FMAX)
        |-> field_idx == $past(field_idx) + 1'b1);

    // R5: saturation
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ($past(field_idx) == FMAX && !$past(load)) |-> field_idx == FMAX);

endmodule

bind shadow_commit_ctrl shadow_commit_chk #(
    .AW     (shadow_commit_pkg::NUM_SET * DATA_W),
    .FIDX_W (FIDX_W),
    .LITE   (LITE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .field_bnd   (field_bnd),
    .load        (load),
    .ctl_req     (ctl_req),
    .pending     (pending),
    .act_all     ({act_aux, act_pat}),
    .gen_run     (gen_run),
    .field_idx   (field_idx),
    .field_phase (field_phase)
);

// File: tb/shadow_commit_ctrl_test.sv
`timescale 1ns/1ps
module shadow_commit_ctrl_test;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic wr_f = 0, rd_f = 0, bnd_f = 0;
    logic wr_l = 0, rd_l = 0, bnd_l = 0;

    logic [DW-1:0]   rdata_f, rdata_l;
    logic [4*DW-1:0] pat_f, aux_f, pat_l, aux_l;
    logic            run_f, run_l, ph_f, ph_l;
    logic [FW-1:0]   idx_f, idx_l;

    shadow_commit_ctrl #(.DATA_W(DW), .ADDR_W(AW), .FIDX_W(FW), .LITE(1'b0)) uut (
        .clk(clk), .rst(rst), .h_wr(wr_f), .h_rd(rd_f), .h_addr(addr),
        .h_wdata(wdata), .h_rdata(rdata_f), .field_bnd(bnd_f),
        .act_pat(pat_f), .act_aux(aux_f), .gen_run(run_f),
        .field_idx(idx_f), .field_phase(ph_f));

    shadow_commit_ctrl #(.DATA_W(DW), .ADDR_W(AW), .FIDX_W(FW), .LITE(1'b1)) uut_lite (
        .clk(clk), .rst(rst), .h_wr(wr_l), .h_rd(rd_l), .h_addr(addr),
        .h_wdata(wdata), .h_rdata(rdata_l), .field_bnd(bnd_l),
        .act_pat(pat_l), .act_aux(aux_l), .gen_run(run_l),
        .field_idx(idx_l), .field_phase(ph_l));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit lite, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (lite) wr_l = 1; else wr_f = 1;
        @(negedge clk);
        wr_l = 0; wr_f = 0;
    endtask

    task automatic rd(input bit lite, input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        if (lite) rd_l = 1; else rd_f = 1;
        @(negedge clk);
        rd_l = 0; rd_f = 0;
        d = lite ? rdata_l : rdata_f;
    endtask

    task automatic bnd(input bit lite);
        @(negedge clk);
        if (lite) bnd_l = 1; else bnd_f = 1;
        @(negedge clk);
        bnd_l = 0; bnd_f = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R9 pat", pat_f[DW-1:0], 0);
        chk("R9 run", {31'b0, run_f}, 0);
        chk("R9 idx", {29'b0, idx_f}, 0);
        rd(0, 12'h140, v);
        chk("R9 status", v, 0);
    endtask

    task automatic t_shadow_hold();
        logic [DW-1:0] v;
        wr(0, 12'h120, 32'hAAAA0001);
        wr(0, 12'h160, 32'hBBBB0002);
        rd(0, 12'h120, v);
        chk("R8 shadow read", v, 32'hAAAA0001);
        rd(0, 12'h140, v);
        chk("R3 pending set", v, 32'h2);
        chk("R1 no apply yet", pat_f[DW-1:0], 0);
        bnd(0);
        chk("R1 boundary without commit", pat_f[DW-1:0], 0);
        wr(0, 12'h14C, 32'h0);
        chk("R1 commit waits boundary", pat_f[DW-1:0], 0);
        bnd(0);
        chk("R1 pat applied", pat_f[DW-1:0], 32'hAAAA0001);
        chk("R1 aux applied", aux_f[DW +: DW], 32'hBBBB0002);
        rd(0, 12'h140, v);
        chk("R3 pending cleared", v, 0);
    endtask

    task automatic t_commit_collision();
        logic [DW-1:0] v;
        wr(0, 12'h124, 32'hCCCC0003);
        @(negedge clk);
        addr = 12'h14C; wdata = 0; wr_f = 1; bnd_f = 1;
        @(negedge clk);
        wr_f = 0; bnd_f = 0;
        chk("R2 deferred", pat_f[DW +: DW], 0);
        rd(0, 12'h140, v);
        chk("R2 still pending", v, 32'h2);
        bnd(0);
        chk("R2 applied next", pat_f[DW +: DW], 32'hCCCC0003);
    endtask

    task automatic t_control();
        logic [DW-1:0] v;
        wr(0, 12'h148, 32'h1);
        chk("R4 run waits", {31'b0, run_f}, 0);
        rd(0, 12'h140, v);
        chk("R4 status no pending", v, 0);
        rd(0, 12'h148, v);
        chk("R4 control readback", v, 1);
        bnd(0);
        chk("R4 running", {31'b0, run_f}, 1);
        rd(0, 12'h140, v);
        chk("R4 status run bit", v, 1);
        chk("R5 idx first", {29'b0, idx_f}, 1);
        chk("R6 phase toggled", {31'b0, ph_f}, 1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 10; i++) bnd(0);
        chk("R5 saturated", {29'b0, idx_f}, 7);
        chk("R6 phase after 10", {31'b0, ph_f}, 1);
    endtask

    task automatic t_pat_reset();
        wr(0, 12'h150, 32'h1);
        wr(0, 12'h14C, 32'h0);
        bnd(0);
        chk("R6 idx reset", {29'b0, idx_f}, 0);
        chk("R6 phase start F1", {31'b0, ph_f}, 1);
        bnd(0);
        chk("R6 idx after", {29'b0, idx_f}, 1);
        chk("R6 phase after", {31'b0, ph_f}, 0);
        wr(0, 12'h160, 32'h7);
        wr(0, 12'h14C, 32'h0);
        bnd(0);
        chk("R6 aux no reset idx", {29'b0, idx_f}, 2);
        chk("R6 aux no reset phase", {31'b0, ph_f}, 1);
        chk("R1 aux slot1", aux_f[DW +: DW], 32'h7);
    endtask

    task automatic t_stop();
        logic [DW-1:0] v;
        wr(0, 12'h148, 32'h0);
        rd(0, 12'h140, v);
        chk("R4 still running", v, 1);
        bnd(0);
        chk("R4 stopped", {31'b0, run_f}, 0);
        rd(0, 12'h140, v);
        chk("R4 status idle", v, 0);
        bnd(0);
        chk("R5 idx holds stopped", {29'b0, idx_f}, 2);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        wr(0, 12'h130, 32'hDEAD0000);
        rd(0, 12'h130, v);
        chk("R8 unmapped read", v, 0);
        rd(0, 12'h14C, v);
        chk("R8 commit read", v, 0);
        rd(0, 12'h120, v);
        chk("R8 unmapped write ignored", v, 32'hAAAA0001);
        rd(0, 12'h140, v);
        chk("R8 no pending from unmapped", v, 0);
    endtask

    task automatic t_lite();
        logic [DW-1:0] v;
        wr(1, 12'h120, 32'hD0D0D0D0);
        bnd(1);
        chk("R7 stopped no load", pat_l[DW-1:0], 0);
        rd(1, 12'h140, v);
        chk("R3 lite pending 0", v, 0);
        wr(1, 12'h14C, 32'h5);
        rd(1, 12'h14C, v);
        chk("R7 commit unmapped", v, 0);
        wr(1, 12'h148, 32'h1);
        chk("R7 waits boundary", pat_l[DW-1:0], 0);
        bnd(1);
        chk("R7 loaded on restart", pat_l[DW-1:0], 32'hD0D0D0D0);
        chk("R7 running", {31'b0, run_l}, 1);
        chk("R6 lite idx reset", {29'b0, idx_l}, 0);
        wr(1, 12'h120, 32'hE0E0E0E0);
        bnd(1);
        chk("R7 running write held", pat_l[DW-1:0], 32'hD0D0D0D0);
        chk("R5 lite idx", {29'b0, idx_l}, 1);
        rd(1, 12'h120, v);
        chk("R8 lite shadow", v, 32'hE0E0E0E0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_shadow_hold();
        t_commit_collision();
        t_control();
        t_saturate();
        t_pat_reset();
        t_stop();
        t_unmapped();
        t_lite();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule